// File: doc/BRIEF.md
# Start-up Zeroing Sequencer for a Synchronous RAM Write Port

This block sits between a user write interface and the single write port of an inferred synchronous RAM. When reset is released, it takes over the port and writes zero to every location, one location per clock. It starts at address 0 and counts upward. Once the last location has been written, it hands the port to the user interface and raises a ready flag. From that point on, user writes pass straight through to the memory in the same cycle.

The block replaces array initialisation written in an initial loop, which synthesis cannot map onto a RAM. It uses a clocked sweep instead. The sweep address is selected onto the memory port by a multiplexer that a two-state controller (zeroing, running) drives. The depth and the word width are parameters, and the address width is derived from the depth. A word could, for example, hold a small status field, a tag and a target address, all of which the sweep clears together.

Top module: `memClearSeq`

## Requirements
- R1: While `rst` is high, `memWe` is low. From the first rising edge with `rst` high, `ready` is low.
- R2: Every memory write made during zeroing carries an all-zero data word.
- R3: On the first cycle after reset is released, the sweep writes address 0. Each following cycle writes the next higher address, with exactly one write per cycle, up to DEPTH-1. This also holds when DEPTH is not a power of two.
- R4: `ready` rises in the cycle after address DEPTH-1 is written, which is DEPTH cycles after reset release. It then stays high until reset.
- R5: While `ready` is low, the user inputs have no effect on the memory port: `memWe`, `memAddr` and `memData` follow the sweep whatever the user drives.
- R6: While `ready` is high, `memWe`, `memAddr` and `memData` equal `userWe`, `userAddr` and `userData` in the same cycle.
- R7: Asserting `rst` while running drops `ready`. After release, the sweep restarts from address 0 and covers the full range again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| userWe | input | 1 | User write enable |
| userAddr | input | ADDR_W | User write address |
| userData | input | DATA_W | User write data |
| memWe | output | 1 | Write enable to the RAM |
| memAddr | output | ADDR_W | Write address to the RAM |
| memData | output | DATA_W | Write data to the RAM |
| ready | output | 1 | High once zeroing is complete |

## Verification
During the sweep, the bench drives random user writes, including some that target the last address with every data bit set. If the memory port then shows anything other than the ascending zero-data sequence, the sweep is leaking user traffic. After the sweep, random user traffic checks the same-cycle pass-through, which separates a registered path from a combinational one. A reset issued in the middle of running, followed by a second full sweep, shows whether the counter restarts at zero and whether the hand-over happens after exactly DEPTH writes. The bench uses a depth that is not a power of two, so that a wrap-based end test cannot pass by accident.

// File: rtl/memclr_pkg.sv
package memclr_pkg;

  typedef enum logic {
    ST_ZEROING = 1'b0,
    ST_RUNNING = 1'b1
  } clrState_t;

  // strobes from the controller to the datapath
  typedef struct packed {
    logic sweepHold;  // force sweep counter to address 0
    logic sweepWr;    // issue one zero write and advance
    logic userPass;   // route user port to memory
  } clrStrobe_t;

endpackage

// File: rtl/memClrCtrl.sv
module memClrCtrl
  import memclr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sweepDone,
  output clrStrobe_t strb,
  output logic       ready
);

  clrState_t stateQ;
  clrState_t stateD;

  always_comb begin
    stateD = stateQ;
    if (stateQ == ST_ZEROING && sweepDone) stateD = ST_RUNNING;
  end

  always_ff @(posedge clk) begin
    if (rst) stateQ <= ST_ZEROING;
    else     stateQ <= stateD;
  end

  always_comb begin
    strb.sweepHold = rst;
    strb.sweepWr   = (stateQ == ST_ZEROING) && !rst;
    strb.userPass  = (stateQ == ST_RUNNING) && !rst;
  end

  assign ready = (stateQ == ST_RUNNING);

  AST_RST_DROPS_READY: assert property (@(posedge clk) rst |=> !ready); // R1

  AST_LAST_ENTERS_RUN: assert property (@(posedge clk) disable iff (rst)
    (strb.sweepWr && sweepDone) |=> ready); // R4

  AST_READY_HOLDS: assert property (@(posedge clk) disable iff (rst)
    ready |=> ready); // R4

endmodule

// File: rtl/memClrPath.sv
module memClrPath
  import memclr_pkg::*;
#(
  parameter int DEPTH  = 16384,
  parameter int DATA_W = 50,
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  clrStrobe_t        strb,
  input  logic              userWe,
  input  logic [ADDR_W-1:0] userAddr,
  input  logic [DATA_W-1:0] userData,
  output logic              sweepDone,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

  logic [ADDR_W-1:0] sweepAddr;

  always_ff @(posedge clk) begin
    if (strb.sweepHold)    sweepAddr <= '0;
    else if (strb.sweepWr) sweepAddr <= sweepAddr + 1'b1;
  end

  assign sweepDone = (sweepAddr == LAST_ADDR);

  // write-port multiplexer: sweep, user, or idle
  always_comb begin
    memWe   = 1'b0;
    memAddr = sweepAddr;
    memData = '0;
    if (strb.sweepWr) begin
      memWe   = 1'b1;
      memAddr = sweepAddr;
      memData = '0;
    end else if (strb.userPass) begin
      memWe   = userWe;
      memAddr = userAddr;
      memData = userData;
    end
  end

  AST_SWEEP_STEP: assert property (@(posedge clk) disable iff (strb.sweepHold)
    (strb.sweepWr && $past(strb.sweepWr)) |-> memAddr == ADDR_W'($past(memAddr) + 1'b1)); // R3

  AST_SWEEP_START: assert property (@(posedge clk)
    ($past(strb.sweepHold) && strb.sweepWr) |-> memAddr == '0); // R7

endmodule

// File: rtl/memClearSeq.sv
module memClearSeq
  import memclr_pkg::*;
#(
  parameter int DEPTH  = 16384,
  parameter int DATA_W = 50,
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              userWe,
  input  logic [ADDR_W-1:0] userAddr,
  input  logic [DATA_W-1:0] userData,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData,
  output logic              ready
);

  clrStrobe_t strb;
  logic       sweepDone;

  memClrCtrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .sweepDone (sweepDone),
    .strb      (strb),
    .ready     (ready)
  );

  memClrPath #(
    .DEPTH  (DEPTH),
    .DATA_W (DATA_W)
  ) u_path (
    .clk       (clk),
    .strb      (strb),
    .userWe    (userWe),
    .userAddr  (userAddr),
    .userData  (userData),
    .sweepDone (sweepDone),
    .memWe     (memWe),
    .memAddr   (memAddr),
    .memData   (memData)
  );

  AST_NO_WRITE_IN_RST: assert property (@(posedge clk) rst |-> !memWe); // R1

  AST_CLEAR_ZERO_DATA: assert property (@(posedge clk) disable iff (rst)
    !ready |-> (memWe && memData == '0)); // R2

  AST_RUN_FOLLOWS_USER: assert property (@(posedge clk) disable iff (rst)
    ready |-> (memWe == userWe && memAddr == userAddr && memData == userData)); // R6

endmodule

// File: tb/memClearSeq_bench.sv
module memClearSeq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH  = 40;
  localparam int DATA_W = 50;
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int PORT_W = 1 + ADDR_W + DATA_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              userWe = 1'b0;
  logic [ADDR_W-1:0] userAddr = '0;
  logic [DATA_W-1:0] userData = '0;
  logic              memWe;
  logic [ADDR_W-1:0] memAddr;
  logic [DATA_W-1:0] memData;
  logic              ready;

  int total = 0;
  int bad   = 0;
  bit doneFlag = 0;

  memClearSeq #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_memClearSeq (
    .clk(clk), .rst(rst), .userWe(userWe), .userAddr(userAddr),
    .userData(userData), .memWe(memWe), .memAddr(memAddr),
    .memData(memData), .ready(ready)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // expected memory port while zeroing: write of zero at sweep index k
  function automatic logic [PORT_W-1:0] expSweep(int k);
    return {1'b1, ADDR_W'(k), {DATA_W{1'b0}}};
  endfunction

  // expected memory port while running: user inputs unchanged
  function automatic logic [PORT_W-1:0] expRun(logic we, logic [ADDR_W-1:0] a,
                                              logic [DATA_W-1:0] d);
    return {we, a, d};
  endfunction

  task automatic check(string req, logic [PORT_W:0] act, logic [PORT_W:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic driveRandom();
    userWe   = 1'($urandom);
    userAddr = ADDR_W'($urandom % DEPTH);
    userData = {$urandom, $urandom};
  endtask

  // called right after a negedge at which rst was dropped
  task automatic runSweep(bit hostile);
    for (int k = 0; k < DEPTH; k++) begin
      if (hostile) begin
        userWe = 1'b1; userAddr = ADDR_W'(DEPTH - 1); userData = '1;
      end else driveRandom();
      #1;
      // R2 R3 R5: zero write to address k, user ignored, ready low
      check("R3", {ready, memWe, memAddr, memData}, {1'b0, expSweep(k)});
      @(negedge clk);
    end
    driveRandom();
    #1;
    // R4: ready after DEPTH writes, port now follows user
    check("R4", {ready, memWe, memAddr, memData},
          {1'b1, expRun(userWe, userAddr, userData)});
    @(negedge clk);
  endtask

  task automatic runTraffic(int n);
    for (int i = 0; i < n; i++) begin
      driveRandom();
      #1;
      check("R6", {ready, memWe, memAddr, memData},
            {1'b1, expRun(userWe, userAddr, userData)});
      @(negedge clk);
    end
  endtask

  task automatic finishRun();
    if (!doneFlag) begin
      doneFlag = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    total++; bad++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    void'($urandom(32'd4242));
    // R1: reset held with user activity
    userWe = 1'b1; userAddr = '1; userData = '1;
    repeat (3) @(negedge clk);
    #1;
    check("R1", {ready, memWe, {(PORT_W-1){1'b0}}}, '0);
    @(negedge clk);
    rst = 1'b0;
    runSweep(1'b1);        // R5 directed: user hammers last address
    runTraffic(200);       // R6 random
    // R7: reset during running
    rst = 1'b1;
    driveRandom();
    #1;
    check("R1", {1'b0, memWe, {(PORT_W-1){1'b0}}}, '0);
    @(negedge clk);
    #1;
    check("R7", {ready, {PORT_W{1'b0}}}, '0);
    @(negedge clk);
    rst = 1'b0;
    runSweep(1'b0);        // R7: full restart from address 0
    runTraffic(100);
    // directed pass-through corners
    userWe = 1'b1; userAddr = ADDR_W'(DEPTH - 1); userData = '1; #1;
    check("R6", {ready, memWe, memAddr, memData}, {1'b1, expRun(1'b1, ADDR_W'(DEPTH - 1), '1)});
    @(negedge clk);
    userWe = 1'b0; userAddr = '0; userData = '0; #1;
    check("R6", {ready, memWe, memAddr, memData}, {1'b1, expRun(1'b0, '0, '0)});
    finishRun();
  end

endmodule